// File: doc/BRIEF.md
# Clock Tick Interrupt Flag Unit

This block keeps four sticky interrupt status flags for a real-time clock timer. Each flag watches one divided tick signal from the timer's divider chain: a 32 Hz, an 8 Hz, a 2 Hz and a 1 Hz tick. When a tick goes from 1 to 0 and the matching bit of a separate mask register is 1, the flag for that tick becomes 1. A flag stays set until software writes a 1 to its bit.

Software reads the flags through an 8-bit register port to learn which tick rate raised the interrupt. The block also drives a single level interrupt request towards the interrupt controller. The request is high whenever any flag is set, so the controller must treat it as a level-triggered source. Clearing the last pending flag drops the request. The tick inputs are sampled in the system clock domain, so edges are found with one register stage per tick.

Top module: `tick_irq_flags`

## Requirements
- R1: After a synchronous reset, all four flags are 0, `rd_data` reads 0x00 and `irq_req` is 0.
- R2: A tick that is sampled at 1 and then at 0 on the next clock, while its enable bit is 1, sets its flag at that second clock edge. The flag positions are: bit 3 is the 32 Hz tick, bit 2 the 8 Hz, bit 1 the 2 Hz and bit 0 the 1 Hz. Index i of `tick_in` and of `tick_enable` drives flag bit i.
- R3: A falling edge that arrives while its enable bit is 0 leaves the flag unchanged.
- R4: A rising edge, or a tick held at a steady level, never sets a flag.
- R5: A cycle with `wr_en` high clears every flag whose `wr_data` bit is 1. Flags whose `wr_data` bit is 0 keep their value.
- R6: Bits 7 to 4 of `rd_data` always read 0, and writes to those bits have no effect.
- R7: `irq_req` is 1 exactly when at least one flag is 1, and it changes on the same clock edge as the flags.
- R8: When a set event and a write-1 clear reach the same flag on the same clock edge, the flag ends up set.
- R9: Turning an enable bit off does not clear a flag that is already set.
- R10: A flag left pending from an earlier enabled period can be cleared while its enable is off. If software clears it first and then sets the enable, `irq_req` stays 0 until a new falling edge arrives.
- R11: The four flags are independent: events on one tick or clear bit do not change any other flag, and several flags can be set on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 8 | Write data; a 1 in bits 3..0 clears the matching flag |
| rd_data | output | 8 | Flag register read value; combinational |
| tick_enable | input | 4 | Per-tick enable bits from the mask register |
| tick_in | input | 4 | Divided tick signals: index 3 = 32 Hz, 2 = 8 Hz, 1 = 2 Hz, 0 = 1 Hz |
| irq_req | output | 1 | Level interrupt request, high while any flag is set |

## Verification
A wrong stored tick sample shows at the ports one clock later. A flag set by a rising edge shows there, and so does a missed falling edge. A flag that is dropped or stuck can be seen in `rd_data` at once, because the read path has no register. It shows in `irq_req` on the same edge. A reference model in the bench steps once per clock and is compared on every cycle, so a wrong flag value is caught in the cycle after the edge that produced it. The timing of the set-versus-clear collision and the order of clearing before enabling get directed sequences of their own. Without them, these cases would be rare under normal tick activity.

// File: rtl/tick_flag_pkg.sv
package tick_flag_pkg;

    // Number of divided tick inputs watched by the block.
    localparam int NUM_TICKS = 4;
    // Width of the software register port.
    localparam int REG_W     = 8;
    // Reserved bits above the flag field.
    localparam int PAD_W     = REG_W - NUM_TICKS;

    // Flag bit positions; software depends on this mapping.
    localparam int IDX_HZ1  = 0;
    localparam int IDX_HZ2  = 1;
    localparam int IDX_HZ8  = 2;
    localparam int IDX_HZ32 = 3;

    typedef logic [NUM_TICKS-1:0] tick_vec_t;
    typedef logic [REG_W-1:0]     reg_word_t;

    // Per-cycle request to the flag storage.
    typedef struct packed {
        tick_vec_t set;
        tick_vec_t clr;
    } flag_cmd_t;

    // A set request beats a clear request on the same bit.
    function automatic tick_vec_t resolve_flags(tick_vec_t cur, flag_cmd_t cmd);
        return (cur & ~cmd.clr) | cmd.set;
    endfunction

    // Place flags in the low bits of a register word; reserved bits are zero.
    function automatic reg_word_t pack_read(tick_vec_t flags);
        return {{PAD_W{1'b0}}, flags};
    endfunction

endpackage

// File: rtl/tick_fall_detect.sv
module tick_fall_detect
    import tick_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tick_vec_t tick_in,
    output tick_vec_t fall_o
);

    tick_vec_t tick_q;

    for (genvar g = 0; g < NUM_TICKS; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) tick_q[g] <= 1'b0;
            else     tick_q[g] <= tick_in[g];
        end
        assign fall_o[g] = tick_q[g] & ~tick_in[g];
    end

    // A detected fall must follow a cycle in which the tick was seen high.
    assert_fall_needs_high_R4: assert property (@(posedge clk) disable iff (rst)
        (fall_o != '0) |-> ((fall_o & ~$past(tick_in)) == '0));

endmodule

// File: rtl/flag_cmd_build.sv
module flag_cmd_build
    import tick_flag_pkg::*;
(
    input  tick_vec_t fall_i,
    input  tick_vec_t enable_i,
    input  logic      wr_en,
    input  reg_word_t wr_data,
    output flag_cmd_t cmd_o
);

    always_comb begin
        cmd_o.set = fall_i & enable_i;
        cmd_o.clr = wr_en ? wr_data[NUM_TICKS-1:0] : '0;
    end

endmodule

// File: rtl/flag_store.sv
module flag_store
    import tick_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_cmd_t cmd_i,
    output tick_vec_t flags_o,
    output logic      irq_o
);

    tick_vec_t flags_next;

    always_comb flags_next = resolve_flags(flags_o, cmd_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
            irq_o   <= 1'b0;
        end else begin
            flags_o <= flags_next;
            irq_o   <= |flags_next;
        end
    end

    // Every requested set shows up one edge later, even under a clear (R2, R8).
    assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.set != '0) |=> ((flags_o & $past(cmd_i.set)) == $past(cmd_i.set)));

    // A clear without a competing set removes the flag.
    assert_clear_lands_R5: assert property (@(posedge clk) disable iff (rst)
        ((cmd_i.clr & ~cmd_i.set) != '0) |=> ((flags_o & $past(cmd_i.clr & ~cmd_i.set)) == '0));

    // No flag rises without a set request.
    assert_no_stray_set_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(cmd_i.set)) == '0));

    // Flags without a clear request never fall (R9).
    assert_hold_without_clear_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~flags_o & $past(flags_o) & ~$past(cmd_i.clr)) == '0));

endmodule

// File: rtl/tick_irq_flags.sv
module tick_irq_flags
    import tick_flag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic [NUM_TICKS-1:0] tick_enable,
    input  logic [NUM_TICKS-1:0] tick_in,
    output logic                 irq_req
);

    tick_vec_t fall;
    tick_vec_t flags;
    flag_cmd_t cmd;

    tick_fall_detect u_fall (
        .clk     (clk),
        .rst     (rst),
        .tick_in (tick_in),
        .fall_o  (fall)
    );

    flag_cmd_build u_cmd (
        .fall_i   (fall),
        .enable_i (tick_enable),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cmd_o    (cmd)
    );

    flag_store u_store (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .flags_o (flags),
        .irq_o   (irq_req)
    );

    assign rd_data = pack_read(flags);

    // Level request tracks the readable flag field on every cycle.
    assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
        irq_req == (rd_data != '0));

    // A masked fall never raises the request from idle.
    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && !wr_en && ((fall & tick_enable) == '0)) |=> !irq_req);

endmodule

// File: tb/tick_irq_flags_tb.sv
`timescale 1ns/1ps
module tick_irq_flags_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [3:0] tick_enable;
    logic [3:0] tick_in;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // Reference state
    bit m_prev [4];
    bit m_flag [4];
    bit m_irq;

    always #2.5 clk = ~clk;

    tick_irq_flags u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .tick_enable (tick_enable),
        .tick_in     (tick_in),
        .irq_req     (irq_req)
    );

    function automatic logic [7:0] model_word();
        logic [7:0] w = 8'h00;
        for (int i = 0; i < 4; i++) w[i] = m_flag[i];
        return w;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        check(tag, rd_data, model_word(), "rd_data");
        check(tag, {7'd0, irq_req}, {7'd0, m_irq}, "irq_req");
    endtask

    // One clock: drive at falling edge, advance the model, compare afterwards.
    task automatic step(string tag, logic [3:0] tk, logic [3:0] en,
                        logic we = 1'b0, logic [7:0] wd = 8'h00);
        bit nf [4];
        tick_in     = tk;
        tick_enable = en;
        wr_en       = we;
        wr_data     = wd;
        for (int i = 0; i < 4; i++) begin
            if (m_prev[i] && !tk[i] && en[i]) nf[i] = 1;
            else if (we && wd[i])             nf[i] = 0;
            else                              nf[i] = m_flag[i];
        end
        @(posedge clk);
        @(negedge clk);
        m_irq = 0;
        for (int i = 0; i < 4; i++) begin
            m_prev[i] = tk[i];
            m_flag[i] = nf[i];
            m_irq     = m_irq | nf[i];
        end
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1;
        tick_in = 4'h0; tick_enable = 4'h0; wr_en = 0; wr_data = 8'h00;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin m_prev[i] = 0; m_flag[i] = 0; end
        m_irq = 0;
        compare("R1");
        rst = 0;
    endtask

    initial begin : watchdog
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        do_reset();
        step("R1", 4'h0, 4'h0);
        check("R1", rd_data, 8'h00, "reset flags");

        // R2: each tick alone, with its enable
        for (int i = 0; i < 4; i++) begin
            step("R2", 4'h1 << i, 4'h1 << i);
            step("R2", 4'h0, 4'h1 << i);
            check("R2", rd_data, 8'h01 << i, "flag position");
            step("R5", 4'h0, 4'h0, 1'b1, 8'h0F);
        end

        // R3: falling edge with enable off
        step("R3", 4'hF, 4'h0);
        step("R3", 4'h0, 4'h0);
        check("R3", rd_data, 8'h00, "masked fall");

        // R4: rising edge and steady levels with enables on
        step("R4", 4'hF, 4'hF);
        step("R4", 4'hF, 4'hF);
        check("R4", rd_data, 8'h00, "rise/steady");

        // R11: all fall together
        step("R11", 4'h0, 4'hF);
        check("R11", rd_data, 8'h0F, "simultaneous set");

        // R5: write 0 does nothing, write 1 clears only chosen bits
        step("R5", 4'h0, 4'hF, 1'b1, 8'h00);
        check("R5", rd_data, 8'h0F, "write zero");
        step("R5", 4'h0, 4'hF, 1'b1, 8'h05);
        check("R5", rd_data, 8'h0A, "partial clear");
        check("R7", {7'd0, irq_req}, 8'h01, "irq with flags");

        // R6: writes to reserved bits
        step("R6", 4'h0, 4'hF, 1'b1, 8'hF0);
        check("R6", rd_data & 8'hF0, 8'h00, "reserved bits");
        check("R6", rd_data, 8'h0A, "reserved write no effect");

        // R7: request drops when last flag cleared
        step("R7", 4'h0, 4'hF, 1'b1, 8'h0A);
        check("R7", {7'd0, irq_req}, 8'h00, "irq cleared");

        // R8: set and clear same edge on bit 2
        step("R8", 4'h4, 4'h4);
        step("R8", 4'h0, 4'h4, 1'b1, 8'h04);
        check("R8", rd_data, 8'h04, "set wins");

        // R9: dropping the enable keeps the flag
        step("R9", 4'h0, 4'h0);
        step("R9", 4'h0, 4'h0);
        check("R9", rd_data, 8'h04, "flag held");

        // R10: clear while disabled, then enable: no request
        step("R10", 4'h0, 4'h0, 1'b1, 8'h04);
        step("R10", 4'h0, 4'h4);
        step("R10", 4'h0, 4'h4);
        check("R10", {7'd0, irq_req}, 8'h00, "no spurious irq");
        step("R10", 4'h4, 4'h4);
        step("R10", 4'h0, 4'h4);
        check("R10", {7'd0, irq_req}, 8'h01, "new edge raises irq");

        // R11: independence across a pattern of mixed activity
        step("R11", 4'h0, 4'hF, 1'b1, 8'h0F);
        for (int k = 0; k < 40; k++) begin
            logic [3:0] tk = 4'((k * 7 + 3) ^ (k >> 1));
            logic [3:0] en = 4'(k * 5 + 9);
            logic       we = (k % 3) == 0;
            logic [7:0] wd = 8'(k * 13);
            step("R11", tk, en, we, wd);
        end

        // R1: reset from a busy state
        step("R1", 4'hF, 4'hF);
        step("R1", 4'h0, 4'hF);
        do_reset();
        step("R1", 4'h0, 4'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule